// File: doc/BRIEF.md
# Cascaded Bit-Slice ALU

A purely combinational arithmetic-logic unit whose word is assembled from identical four-bit slices. Each slice holds four single-bit cells. Every cell in every slice sees the same three-bit operation code. The carry runs from bit 0 of the lowest slice up through each slice in turn. The carry out of the top bit of the word is the carry output of the block. The word width is a parameter, and it must be a positive multiple of four.

The operation set has eight entries. Two are arithmetic: a plain add, and an add of the inverted second operand, which gives two's-complement subtraction when the carry input is 1. Four are bitwise logic operations, two of them on the inverted second operand. The last two pass one operand straight through. The block keeps no state. The results settle from the inputs with no clock involved.

Top module: `bsl_alu`

## Requirements
- R1: The word width `WIDTH` is a positive multiple of 4 and is built from `WIDTH/4` identical four-bit slices. Elaboration stops with an error for any other width. Results are correct across slice boundaries for every width, including the single-slice width 4.
- R2: All slices obey the one shared 3-bit code `op_i`. No slice decodes it differently from another.
- R3: Code 3'd0 (add): `result_o` = (`a_i` + `b_i` + `carry_i`) mod 2^WIDTH, and `carry_o` is the carry out of that sum.
- R4: Code 3'd1 (add inverted B): `result_o` = (`a_i` + ~`b_i` + `carry_i`) mod 2^WIDTH, and `carry_o` is the carry out of that sum. With `carry_i` = 1 this is `a_i` − `b_i`, and `carry_o` = 1 exactly when `a_i` ≥ `b_i` (unsigned).
- R5: Codes 3'd2, 3'd3, 3'd4 and 3'd5 give `a_i & b_i`, `a_i & ~b_i`, `a_i | b_i` and `a_i | ~b_i` respectively.
- R6: Code 3'd6 gives `b_i` unchanged, and code 3'd7 gives `a_i` unchanged.
- R7: For codes 3'd2 to 3'd7, `carry_o` is 0 and `result_o` does not depend on `carry_i`.
- R8: `carry_i` enters at bit 0 and propagates through every slice. For example, all-ones plus 0 with `carry_i` = 1 under code 3'd0 gives a zero result and `carry_o` = 1.
- R9: The block holds no state. The outputs follow the current inputs with no clock cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| carry_i | input | 1 | Carry into bit 0 |
| op_i | input | 3 | Operation code shared by all slices |
| result_o | output | WIDTH | Result word |
| carry_o | output | 1 | Carry out of the top bit |

## Verification
Both outputs are due in the same cycle as the stimulus, with no latency, because the block has no registers. The bench changes the inputs on the falling clock edge and samples both outputs one nanosecond after the next rising edge. The ripple through every slice therefore has settled long before the sample is taken. No check ever waits a cycle beyond the one in which its stimulus was applied.

// File: rtl/bsl_alu_pkg.sv
package bsl_alu_pkg;

    localparam int SLICE_W = 4;

    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_ADDNB = 3'd1,
        OP_AND   = 3'd2,
        OP_ANDNB = 3'd3,
        OP_OR    = 3'd4,
        OP_ORNB  = 3'd5,
        OP_PASSB = 3'd6,
        OP_PASSA = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic res;
        logic carry;
    } cell_out_t;

    function automatic logic uses_inv_b(alu_op_e op);
        return (op == OP_ADDNB) || (op == OP_ANDNB) || (op == OP_ORNB);
    endfunction

    function automatic logic is_arith(alu_op_e op);
        return (op == OP_ADD) || (op == OP_ADDNB);
    endfunction

    function automatic cell_out_t cell_eval(logic a, logic b, logic c, alu_op_e op);
        cell_out_t o;
        logic      bx;
        bx = uses_inv_b(op) ? ~b : b;
        o  = '{res: 1'b0, carry: 1'b0};
        case (op)
            OP_ADD, OP_ADDNB: begin
                o.res   = a ^ bx ^ c;
                o.carry = (a & bx) | (a & c) | (bx & c);
            end
            OP_AND, OP_ANDNB: o.res = a & bx;
            OP_OR,  OP_ORNB:  o.res = a | bx;
            OP_PASSB:         o.res = b;
            OP_PASSA:         o.res = a;
            default:          o = '{res: 1'b0, carry: 1'b0};
        endcase
        return o;
    endfunction

endpackage

// File: rtl/bsl_cell.sv
module bsl_cell
    import bsl_alu_pkg::*;
(
    input  logic    a_i,
    input  logic    b_i,
    input  logic    c_i,
    input  alu_op_e op_i,
    output logic    res_o,
    output logic    carry_o
);

    cell_out_t cell_q;

    always_comb begin
        cell_q  = cell_eval(a_i, b_i, c_i, op_i);
        res_o   = cell_q.res;
        carry_o = cell_q.carry;

        if (!$isunknown({a_i, b_i, c_i, op_i})) begin
            // R3: the sum bit differs from a^b exactly by the incoming carry
            if (op_i == OP_ADD)
                p_add_sum_r3: assert ((cell_q.res ^ c_i) == (a_i ^ b_i))
                    else $error("add cell sum wrong");
            // R4: with B inverted, the sum bit tracks xnor of the operands
            if (op_i == OP_ADDNB)
                p_addnb_sum_r4: assert ((cell_q.res ^ c_i) == ~(a_i ^ b_i))
                    else $error("inverted-B add cell sum wrong");
            // R6: pass-through codes copy one operand
            if (op_i == OP_PASSB)
                p_pass_b_r6: assert (cell_q.res == b_i)
                    else $error("pass B wrong");
            if (op_i == OP_PASSA)
                p_pass_a_r6: assert (cell_q.res == a_i)
                    else $error("pass A wrong");
            // R7: non-arithmetic codes never generate a carry
            if (!is_arith(op_i))
                p_logic_carry_zero_r7: assert (cell_q.carry == 1'b0)
                    else $error("logic code produced a carry");
        end
    end

endmodule

// File: rtl/bsl_slice.sv
module bsl_slice
    import bsl_alu_pkg::*;
(
    input  logic [SLICE_W-1:0] a_i,
    input  logic [SLICE_W-1:0] b_i,
    input  logic               c_i,
    input  alu_op_e            op_i,
    output logic [SLICE_W-1:0] res_o,
    output logic               c_o
);

    logic [SLICE_W:0] chain;

    assign chain[0] = c_i;

    for (genvar k = 0; k < SLICE_W; k++) begin : g_cell
        bsl_cell u_cell (
            .a_i     (a_i[k]),
            .b_i     (b_i[k]),
            .c_i     (chain[k]),
            .op_i    (op_i),
            .res_o   (res_o[k]),
            .carry_o (chain[k+1])
        );
    end

    assign c_o = chain[SLICE_W];

endmodule

// File: rtl/bsl_alu.sv
module bsl_alu
    import bsl_alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             carry_i,
    input  logic [2:0]       op_i,
    output logic [WIDTH-1:0] result_o,
    output logic             carry_o
);

    localparam int N_SLICES = WIDTH / SLICE_W;

    // R1: only whole slices are allowed
    if ((WIDTH <= 0) || ((WIDTH % SLICE_W) != 0)) begin : g_bad_width
        $error("bsl_alu: WIDTH must be a positive multiple of the slice width");
    end

    alu_op_e           op_shared;
    logic [N_SLICES:0] link;

    // R2: one decoded code fans out to every slice
    assign op_shared = alu_op_e'(op_i);
    assign link[0]   = carry_i;

    for (genvar s = 0; s < N_SLICES; s++) begin : g_slice
        bsl_slice u_slice (
            .a_i   (a_i[s*SLICE_W +: SLICE_W]),
            .b_i   (b_i[s*SLICE_W +: SLICE_W]),
            .c_i   (link[s]),
            .op_i  (op_shared),
            .res_o (result_o[s*SLICE_W +: SLICE_W]),
            .c_o   (link[s+1])
        );
    end

    assign carry_o = link[N_SLICES];

endmodule

// File: tb/bsl_alu_tb.sv
`timescale 1ns / 1ps
module bsl_alu_tb;

    localparam int W  = 16;
    localparam int WS = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;  // 250 MHz

    logic [W-1:0]  a, b, res;
    logic          cin, cout;
    logic [2:0]    op;
    logic [WS-1:0] a4, b4, res4;
    logic          cin4, cout4;
    logic [2:0]    op4;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done     = 0;

    bsl_alu #(.WIDTH(W)) u_dut (
        .a_i(a), .b_i(b), .carry_i(cin), .op_i(op),
        .result_o(res), .carry_o(cout)
    );

    bsl_alu #(.WIDTH(WS)) u_dut4 (
        .a_i(a4), .b_i(b4), .carry_i(cin4), .op_i(op4),
        .result_o(res4), .carry_o(cout4)
    );

    function automatic logic [W:0] ref16(logic [W-1:0] x, logic [W-1:0] y, logic c, logic [2:0] o);
        case (o)
            3'd0: return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
            3'd1: return {1'b0, x} + {1'b0, ~y} + {{W{1'b0}}, c};
            3'd2: return {1'b0, x & y};
            3'd3: return {1'b0, x & ~y};
            3'd4: return {1'b0, x | y};
            3'd5: return {1'b0, x | ~y};
            3'd6: return {1'b0, y};
            default: return {1'b0, x};
        endcase
    endfunction

    function automatic logic [WS:0] ref4(logic [WS-1:0] x, logic [WS-1:0] y, logic c, logic [2:0] o);
        case (o)
            3'd0: return {1'b0, x} + {1'b0, y} + {{WS{1'b0}}, c};
            3'd1: return {1'b0, x} + {1'b0, ~y} + {{WS{1'b0}}, c};
            3'd2: return {1'b0, x & y};
            3'd3: return {1'b0, x & ~y};
            3'd4: return {1'b0, x | y};
            3'd5: return {1'b0, x | ~y};
            3'd6: return {1'b0, y};
            default: return {1'b0, x};
        endcase
    endfunction

    function automatic string tag_of(logic [2:0] o);
        case (o)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd6, 3'd7: return "R6";
            default: return "R5";
        endcase
    endfunction

    task automatic check16(string tag, logic [W-1:0] x, logic [W-1:0] y, logic c, logic [2:0] o);
        logic [W:0] exp;
        @(negedge clk);
        a = x; b = y; cin = c; op = o;
        exp = ref16(x, y, c, o);
        @(posedge clk);
        #1;
        n_checks++;
        if ({cout, res} !== exp) begin
            n_errors++;
            $display("FAIL %s op=%0d a=%h b=%h cin=%0d: got cout=%0d res=%h, expected cout=%0d res=%h",
                     tag, o, x, y, c, cout, res, exp[W], exp[W-1:0]);
        end
    endtask

    task automatic check4(logic [WS-1:0] x, logic [WS-1:0] y, logic c, logic [2:0] o);
        logic [WS:0] exp;
        @(negedge clk);
        a4 = x; b4 = y; cin4 = c; op4 = o;
        exp = ref4(x, y, c, o);
        @(posedge clk);
        #1;
        n_checks++;
        if ({cout4, res4} !== exp) begin
            n_errors++;
            $display("FAIL R1 width4 op=%0d a=%h b=%h cin=%0d: got cout=%0d res=%h, expected cout=%0d res=%h",
                     o, x, y, c, cout4, res4, exp[WS], exp[WS-1:0]);
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        a = '0; b = '0; cin = 1'b0; op = 3'd0;
        a4 = '0; b4 = '0; cin4 = 1'b0; op4 = 3'd0;

        // R9: all-zero inputs give zero at once, no state
        check16("R9", 16'h0000, 16'h0000, 1'b0, 3'd0);
        // R8: carry in ripples across every slice
        check16("R8", 16'hFFFF, 16'h0000, 1'b1, 3'd0);
        check16("R8", 16'h000F, 16'h0000, 1'b1, 3'd0);
        // R1: slice boundary crossing
        check16("R1", 16'h00FF, 16'h0001, 1'b0, 3'd0);
        // R3: add overflow out the top
        check16("R3", 16'h8000, 16'h8000, 1'b0, 3'd0);
        // R4: subtract with and without borrow
        check16("R4", 16'h1234, 16'h1234, 1'b1, 3'd1);
        check16("R4", 16'h0001, 16'h0002, 1'b1, 3'd1);
        check16("R4", 16'h5000, 16'h0FFF, 1'b0, 3'd1);
        // R5 / R6 directed
        check16("R5", 16'hF0F0, 16'hCCCC, 1'b0, 3'd2);
        check16("R5", 16'hF0F0, 16'hCCCC, 1'b1, 3'd3);
        check16("R5", 16'hF0F0, 16'hCCCC, 1'b0, 3'd4);
        check16("R5", 16'hF0F0, 16'hCCCC, 1'b1, 3'd5);
        check16("R6", 16'hA5A5, 16'h3C3C, 1'b1, 3'd6);
        check16("R6", 16'hA5A5, 16'h3C3C, 1'b1, 3'd7);
        // R7: logic codes with carry in high and all-ones operands
        for (int k = 2; k < 8; k++) begin
            check16("R7", 16'hFFFF, 16'hFFFF, 1'b1, 3'(k));
        end

        // R2: random operands under every shared code
        for (int n = 0; n < 2000; n++) begin
            logic [2:0] o;
            o = 3'($urandom_range(0, 7));
            check16(tag_of(o), 16'($urandom), 16'($urandom), 1'($urandom), o);
        end

        // R1: exhaustive single-slice instance
        for (int o = 0; o < 8; o++)
            for (int c = 0; c < 2; c++)
                for (int x = 0; x < 16; x++)
                    for (int y = 0; y < 16; y++)
                        check4(4'(x), 4'(y), 1'(c), 3'(o));

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired");
            $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule